// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the memory-mapped configuration store of an interrupt distributor serving 128 interrupt lines and up to 8 CPUs. A simple full-word register bus accesses it: a word address, a write strobe, write data and a combinational read data path. Every access also carries the index of the requesting CPU. That index selects the private copy of any word that covers interrupts 0 to 31.

The bank holds four kinds of state. The first is a global distributor enable. The second is a per-interrupt enable bit and the third a per-interrupt pending bit, both reached through paired set and clear windows. The fourth is a priority byte per interrupt and a one-bit edge/level selection per interrupt, which is presented to software as a two-bit field. Software interrupts 0 to 15 can never be disabled, and the private interrupts 0 to 31 are always configured as edge.

A one-cycle strobe marks each write that may change which interrupts are pending. A downstream evaluator uses it to recompute pending state only when needed.

Top module: `dist_regs`

## Requirements
- R1: After reset the control word reads 0 and every pending bit and priority byte is 0. Enable word 0 reads 0x0000FFFF for every CPU. Configuration words 0 and 1 read 0xAAAAAAAA, and the higher configuration words read 0.
- R2: Offset 0x000 is the control word. Only bit 0 (distributor enable) is stored, and every other bit reads 0. A write to it raises the change strobe.
- R3: Offset 0x004 reads ((NUM_CPU-1)<<5) | (NUM_IRQ/32-1), which is 0xE3 by default. Writes to it have no effect.
- R4: Offset 0x008 always reads 0x4B00043B, and writes to it are ignored.
- R5: Word k of the set-enable window (0x100+4k) sets the enable bits where the write data is 1. Word k of the clear-enable window (0x180+4k) clears them. Both windows read the current enable bits of interrupts 32k..32k+31.
- R6: Enable bits 15:0 of word 0 are always 1 for every CPU, even right after a clear-enable write of all ones.
- R7: Pending bits use the same set and clear rules at 0x200+4k and 0x280+4k, and both windows read the current pending bits.
- R8: The group window (0x080), the active windows (0x300 and 0x380) and every offset that decodes to no register read 0 and ignore writes. This includes 0x110, which lies just past the last enable word.
- R9: The priority bytes at 0x400+4k are stored as full words and read back unchanged. A write there raises no change strobe.
- R10: Configuration word k at 0xC00+4k covers interrupts 16k..16k+15. For each interrupt only the odd bit of its two-bit field (1 = edge) is stored. Even bits always read 0, and a write there raises no change strobe.
- R11: Any write to configuration word 0 ignores its data and forces the stored edge bits of all 32 private interrupts of the requesting CPU to 1.
- R12: Enable word 0, pending word 0, priority words 0..7 and configuration words 0..1 are kept separately for each CPU and selected by the CPU index. All higher words are shared by every CPU.
- R13: The change strobe is high for exactly the one cycle after a write to the control, set-enable, clear-enable, set-pending or clear-pending windows, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_i | input | 3 | Index of the CPU making the access |
| addr_i | input | 12 | Byte offset of the accessed word (bits 1:0 ignored) |
| we_i | input | 1 | Write strobe for the current access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i and cpu_i, combinational |
| state_chg_o | output | 1 | One-cycle strobe after a write that can alter pending status |

## Verification
The bench targets the banking boundary. It writes the private enable, priority and configuration words from one CPU and reads them from another. A design that shared word 0 would leak one CPU's bits into the other CPU's reads, and one that banked word 1 would hide a shared write.

The bench also clears every enable bit of word 0 and writes configuration word 0 with zeros. A design without the forced bits would read back zeros there instead of 0x0000FFFF and 0xAAAAAAAA.

Writes that set only an even bit of a configuration field must read back as 0, because a design storing both bits would echo the written data. The bench also checks the strobe after each write. A design that strobed on priority or configuration writes, or held the strobe for more than one cycle, would show a stray pulse.

// File: rtl/dist_pkg.sv
package dist_pkg;

  localparam logic [11:0] OFS_CTRL  = 12'h000;
  localparam logic [11:0] OFS_TYPE  = 12'h004;
  localparam logic [11:0] OFS_IDENT = 12'h008;
  localparam logic [11:0] OFS_SETEN = 12'h100;
  localparam logic [11:0] OFS_CLREN = 12'h180;
  localparam logic [11:0] OFS_SETPD = 12'h200;
  localparam logic [11:0] OFS_CLRPD = 12'h280;
  localparam logic [11:0] OFS_PRIO  = 12'h400;
  localparam logic [11:0] OFS_CFG   = 12'hC00;

  localparam logic [31:0] IDENT_VAL = 32'h4B00043B;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_TYPE, SEL_IDENT,
    SEL_SETEN, SEL_CLREN, SEL_SETPD, SEL_CLRPD,
    SEL_PRIO, SEL_CFG
  } reg_sel_e;

  // 16 stored edge bits -> 32-bit register view, even bits zero
  function automatic logic [31:0] cfg_expand(logic [15:0] h);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) r[2*i+1] = h[i];
    return r;
  endfunction

  function automatic logic [15:0] cfg_compress(logic [31:0] w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = w[2*i+1];
    return r;
  endfunction

endpackage

// File: rtl/dist_decode.sv
module dist_decode
  import dist_pkg::*;
#(
  parameter int NUM_IRQ = 128,
  localparam int BIT_WORDS  = NUM_IRQ / 32,
  localparam int PRIO_WORDS = NUM_IRQ / 4,
  localparam int CFG_WORDS  = NUM_IRQ / 16,
  localparam int IDX_W      = $clog2(PRIO_WORDS)
) (
  input  logic [11:0]      addr_i,
  output reg_sel_e         sel_o,
  output logic [IDX_W-1:0] idx_o
);

  function automatic logic in_win(logic [11:0] a, logic [11:0] base, int nwords);
    logic [12:0] lo, hi;
    lo = {1'b0, base};
    hi = lo + 13'(nwords * 4);
    return ({1'b0, a} >= lo) && ({1'b0, a} < hi);
  endfunction

  logic [11:0] base;
  logic [12:0] off;
  logic        unused_off;

  always_comb begin
    sel_o = SEL_NONE;
    base  = '0;
    if (in_win(addr_i, OFS_CTRL, 1))              sel_o = SEL_CTRL;
    else if (in_win(addr_i, OFS_TYPE, 1))         sel_o = SEL_TYPE;
    else if (in_win(addr_i, OFS_IDENT, 1))        sel_o = SEL_IDENT;
    else if (in_win(addr_i, OFS_SETEN, BIT_WORDS)) begin sel_o = SEL_SETEN; base = OFS_SETEN; end
    else if (in_win(addr_i, OFS_CLREN, BIT_WORDS)) begin sel_o = SEL_CLREN; base = OFS_CLREN; end
    else if (in_win(addr_i, OFS_SETPD, BIT_WORDS)) begin sel_o = SEL_SETPD; base = OFS_SETPD; end
    else if (in_win(addr_i, OFS_CLRPD, BIT_WORDS)) begin sel_o = SEL_CLRPD; base = OFS_CLRPD; end
    else if (in_win(addr_i, OFS_PRIO, PRIO_WORDS)) begin sel_o = SEL_PRIO;  base = OFS_PRIO;  end
    else if (in_win(addr_i, OFS_CFG, CFG_WORDS))   begin sel_o = SEL_CFG;   base = OFS_CFG;   end
  end

  assign off        = {1'b0, addr_i} - {1'b0, base};
  assign idx_o      = off[IDX_W+1:2];
  assign unused_off = ^{off[12:IDX_W+2], off[1:0]};

endmodule

// File: rtl/dist_bitbank.sv
// One bit per interrupt, set/clear write windows, word 0 banked per CPU
module dist_bitbank #(
  parameter int          NUM_IRQ    = 128,
  parameter int          NUM_CPU    = 8,
  parameter logic [31:0] FORCE_MASK = 32'h0,
  localparam int BIT_WORDS = NUM_IRQ / 32,
  localparam int SH_WORDS  = BIT_WORDS - 1,
  localparam int BW        = (BIT_WORDS > 1) ? $clog2(BIT_WORDS) : 1,
  localparam int SHW       = (SH_WORDS > 1) ? $clog2(SH_WORDS) : 1,
  localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CPU_W-1:0] cpu_i,
  input  logic [BW-1:0]    idx_i,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);

  logic [NUM_CPU-1:0][31:0]  priv_q;
  logic [SH_WORDS-1:0][31:0] sh_q;
  logic [SHW-1:0]            sh_idx;
  logic [31:0]               set_m, clr_m;
  logic                      wr;

  assign sh_idx = SHW'(idx_i - BW'(1));
  assign set_m  = set_we_i ? wdata_i : '0;
  assign clr_m  = clr_we_i ? wdata_i : '0;
  assign wr     = set_we_i | clr_we_i;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_priv
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        priv_q[c] <= FORCE_MASK;
      else if (wr && idx_i == '0 && cpu_i == CPU_W'(c))
        priv_q[c] <= ((priv_q[c] | set_m) & ~clr_m) | FORCE_MASK;
    end
  end

  for (genvar g = 0; g < SH_WORDS; g++) begin : g_sh
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        sh_q[g] <= '0;
      else if (wr && idx_i != '0 && sh_idx == SHW'(g))
        sh_q[g] <= (sh_q[g] | set_m) & ~clr_m;
    end
  end

  assign rdata_o = (idx_i == '0) ? priv_q[cpu_i] : sh_q[sh_idx];

endmodule

// File: rtl/dist_prio_bank.sv
// Priority bytes, four per word; first 32 interrupts banked per CPU
module dist_prio_bank #(
  parameter int NUM_IRQ = 128,
  parameter int NUM_CPU = 8,
  localparam int PV_WORDS = 8,
  localparam int SH_WORDS = NUM_IRQ / 4 - PV_WORDS,
  localparam int IW       = $clog2(NUM_IRQ / 4),
  localparam int SHW      = (SH_WORDS > 1) ? $clog2(SH_WORDS) : 1,
  localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CPU_W-1:0] cpu_i,
  input  logic [IW-1:0]    idx_i,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);

  logic [NUM_CPU-1:0][PV_WORDS-1:0][31:0] priv_q;
  logic [SH_WORDS-1:0][31:0]              sh_q;
  logic                                   is_priv;
  logic [2:0]                             pv_idx;
  logic [SHW-1:0]                         sh_idx;

  assign is_priv = idx_i < IW'(PV_WORDS);
  assign pv_idx  = idx_i[2:0];
  assign sh_idx  = SHW'(idx_i - IW'(PV_WORDS));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar w = 0; w < PV_WORDS; w++) begin : g_w
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          priv_q[c][w] <= '0;
        else if (we_i && is_priv && cpu_i == CPU_W'(c) && pv_idx == 3'(w))
          priv_q[c][w] <= wdata_i;
      end
    end
  end

  for (genvar g = 0; g < SH_WORDS; g++) begin : g_sh
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        sh_q[g] <= '0;
      else if (we_i && !is_priv && sh_idx == SHW'(g))
        sh_q[g] <= wdata_i;
    end
  end

  assign rdata_o = is_priv ? priv_q[cpu_i][pv_idx] : sh_q[sh_idx];

endmodule

// File: rtl/dist_cfg_bank.sv
// Edge/level selection, one stored bit per interrupt, two-bit view on the bus
module dist_cfg_bank
  import dist_pkg::*;
#(
  parameter int NUM_IRQ = 128,
  parameter int NUM_CPU = 8,
  localparam int CFG_WORDS = NUM_IRQ / 16,
  localparam int SH_HALF   = CFG_WORDS - 2,
  localparam int CW        = $clog2(CFG_WORDS),
  localparam int SHW       = (SH_HALF > 1) ? $clog2(SH_HALF) : 1,
  localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CPU_W-1:0] cpu_i,
  input  logic [CW-1:0]    idx_i,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);

  logic [NUM_CPU-1:0][31:0]  priv_q;
  logic [SH_HALF-1:0][15:0]  sh_q;
  logic [SHW-1:0]            sh_idx;
  logic [15:0]               wr_bits;
  logic [15:0]               rd_bits;

  assign sh_idx  = SHW'(idx_i - CW'(2));
  assign wr_bits = cfg_compress(wdata_i);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_priv
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        priv_q[c] <= '1;
      else if (we_i && cpu_i == CPU_W'(c)) begin
        if (idx_i == CW'(0))      priv_q[c]        <= '1;  // written data dropped
        else if (idx_i == CW'(1)) priv_q[c][31:16] <= wr_bits;
      end
    end
  end

  for (genvar g = 0; g < SH_HALF; g++) begin : g_sh
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        sh_q[g] <= '0;
      else if (we_i && idx_i >= CW'(2) && sh_idx == SHW'(g))
        sh_q[g] <= wr_bits;
    end
  end

  always_comb begin
    if (idx_i == CW'(0))      rd_bits = priv_q[cpu_i][15:0];
    else if (idx_i == CW'(1)) rd_bits = priv_q[cpu_i][31:16];
    else                      rd_bits = sh_q[sh_idx];
  end

  assign rdata_o = cfg_expand(rd_bits);

endmodule

// File: rtl/dist_regs.sv
module dist_regs
  import dist_pkg::*;
#(
  parameter int NUM_IRQ = 128,
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int IDX_W  = $clog2(NUM_IRQ / 4),
  localparam int BW     = $clog2(NUM_IRQ / 32),
  localparam int CW     = $clog2(NUM_IRQ / 16),
  localparam logic [31:0] SGI_MASK = 32'((64'd1 << NUM_SGI) - 64'd1),
  localparam logic [31:0] TYPE_VAL = 32'(((NUM_CPU - 1) << 5) | (NUM_IRQ / 32 - 1))
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CPU_W-1:0] cpu_i,
  input  logic [11:0]      addr_i,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             state_chg_o
);

  reg_sel_e         sel;
  logic [IDX_W-1:0] idx;
  logic             en_q, chg_q;
  logic [31:0]      en_rd, pd_rd, pr_rd, cfg_rd;
  logic             chg_wr;

  dist_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .idx_o  (idx)
  );

  dist_bitbank #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .FORCE_MASK(SGI_MASK)) u_enable (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cpu_i    (cpu_i),
    .idx_i    (idx[BW-1:0]),
    .set_we_i (we_i && sel == SEL_SETEN),
    .clr_we_i (we_i && sel == SEL_CLREN),
    .wdata_i  (wdata_i),
    .rdata_o  (en_rd)
  );

  dist_bitbank #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .FORCE_MASK(32'h0)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cpu_i    (cpu_i),
    .idx_i    (idx[BW-1:0]),
    .set_we_i (we_i && sel == SEL_SETPD),
    .clr_we_i (we_i && sel == SEL_CLRPD),
    .wdata_i  (wdata_i),
    .rdata_o  (pd_rd)
  );

  dist_prio_bank #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cpu_i   (cpu_i),
    .idx_i   (idx),
    .we_i    (we_i && sel == SEL_PRIO),
    .wdata_i (wdata_i),
    .rdata_o (pr_rd)
  );

  dist_cfg_bank #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cpu_i   (cpu_i),
    .idx_i   (idx[CW-1:0]),
    .we_i    (we_i && sel == SEL_CFG),
    .wdata_i (wdata_i),
    .rdata_o (cfg_rd)
  );

  // writes that can change what is pending
  always_comb begin
    unique case (sel)
      SEL_CTRL, SEL_SETEN, SEL_CLREN, SEL_SETPD, SEL_CLRPD: chg_wr = we_i;
      default:                                              chg_wr = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      chg_q <= chg_wr;
      if (we_i && sel == SEL_CTRL) en_q <= wdata_i[0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:             rdata_o = {31'b0, en_q};
      SEL_TYPE:             rdata_o = TYPE_VAL;
      SEL_IDENT:            rdata_o = IDENT_VAL;
      SEL_SETEN, SEL_CLREN: rdata_o = en_rd;
      SEL_SETPD, SEL_CLRPD: rdata_o = pd_rd;
      SEL_PRIO:             rdata_o = pr_rd;
      SEL_CFG:              rdata_o = cfg_rd;
      default:              rdata_o = '0;
    endcase
  end

  assign state_chg_o = chg_q;

endmodule

// File: rtl/dist_regs_chk.sv
module dist_regs_chk
  import dist_pkg::*;
#(
  parameter int NUM_IRQ = 128,
  parameter int NUM_CPU = 8,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam logic [31:0] TYPE_EXP = 32'(((NUM_CPU - 1) << 5) | (NUM_IRQ / 32 - 1))
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CPU_W-1:0] cpu_i,
  input logic [11:0]      addr_i,
  input logic             we_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      rdata_o,
  input logic             state_chg_o
);

  logic in_cfg, in_raz, unused_chk;
  assign in_cfg     = addr_i >= OFS_CFG && addr_i < OFS_CFG + 12'(NUM_IRQ / 4);
  assign in_raz     = (addr_i >= 12'h080 && addr_i < 12'h080 + 12'(NUM_IRQ / 8)) ||
                      (addr_i >= 12'h300 && addr_i < 12'h300 + 12'(NUM_IRQ / 4));
  assign unused_chk = ^{cpu_i, wdata_i};

  assert_ctrl_hi_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == OFS_CTRL |-> rdata_o[31:1] == '0);

  assert_ctrl_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == OFS_CTRL |=> state_chg_o);

  assert_type_const_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == OFS_TYPE |-> rdata_o == TYPE_EXP);

  assert_ident_const_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == OFS_IDENT |-> rdata_o == IDENT_VAL);

  assert_sgi_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_SETEN || addr_i == OFS_CLREN) |-> rdata_o[15:0] == 16'hFFFF);

  assert_raz_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_raz |-> rdata_o == '0);

  assert_cfg_even_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_cfg |-> (rdata_o & 32'h55555555) == '0);

  assert_stb_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> !state_chg_o);

endmodule

bind dist_regs dist_regs_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_i       (cpu_i),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .state_chg_o (state_chg_o)
);

// File: tb/tb_dist_regs.sv
module tb_dist_regs;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 48;

  typedef struct packed {
    logic        wr;
    logic        stb;   // expected strobe after a write
    logic [2:0]  cpu;
    logic [11:0] addr;
    logic [31:0] dat;   // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  // R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 R13 exercised below
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 3'd0, 12'h000, 32'h00000001, 4'd2},  // R2
    '{1'b0, 1'b0, 3'd0, 12'h000, 32'h00000001, 4'd2},
    '{1'b1, 1'b1, 3'd0, 12'h000, 32'hFFFFFFFE, 4'd2},
    '{1'b0, 1'b0, 3'd0, 12'h000, 32'h00000000, 4'd2},
    '{1'b0, 1'b0, 3'd0, 12'h004, 32'h000000E3, 4'd3},  // R3
    '{1'b1, 1'b0, 3'd0, 12'h004, 32'h12345678, 4'd3},
    '{1'b0, 1'b0, 3'd0, 12'h004, 32'h000000E3, 4'd3},
    '{1'b1, 1'b0, 3'd0, 12'h008, 32'h00000000, 4'd4},  // R4
    '{1'b0, 1'b0, 3'd0, 12'h008, 32'h4B00043B, 4'd4},
    '{1'b1, 1'b1, 3'd1, 12'h104, 32'h00F0000F, 4'd5},  // R5
    '{1'b0, 1'b0, 3'd2, 12'h184, 32'h00F0000F, 4'd5},
    '{1'b1, 1'b1, 3'd1, 12'h184, 32'h0000000F, 4'd5},
    '{1'b0, 1'b0, 3'd1, 12'h104, 32'h00F00000, 4'd5},
    '{1'b1, 1'b1, 3'd3, 12'h100, 32'hFFFF0000, 4'd12}, // R12
    '{1'b0, 1'b0, 3'd3, 12'h100, 32'hFFFFFFFF, 4'd12},
    '{1'b0, 1'b0, 3'd4, 12'h100, 32'h0000FFFF, 4'd12},
    '{1'b1, 1'b1, 3'd3, 12'h180, 32'hFFFFFFFF, 4'd6},  // R6
    '{1'b0, 1'b0, 3'd3, 12'h180, 32'h0000FFFF, 4'd6},
    '{1'b1, 1'b1, 3'd0, 12'h200, 32'h80000001, 4'd7},  // R7
    '{1'b0, 1'b0, 3'd0, 12'h280, 32'h80000001, 4'd7},
    '{1'b0, 1'b0, 3'd5, 12'h200, 32'h00000000, 4'd12},
    '{1'b1, 1'b1, 3'd0, 12'h20C, 32'hA5000000, 4'd7},
    '{1'b1, 1'b1, 3'd0, 12'h28C, 32'h05000000, 4'd7},
    '{1'b0, 1'b0, 3'd6, 12'h20C, 32'hA0000000, 4'd7},
    '{1'b1, 1'b0, 3'd0, 12'h080, 32'hFFFFFFFF, 4'd8},  // R8
    '{1'b0, 1'b0, 3'd0, 12'h080, 32'h00000000, 4'd8},
    '{1'b1, 1'b0, 3'd0, 12'h300, 32'hFFFFFFFF, 4'd8},
    '{1'b0, 1'b0, 3'd0, 12'h300, 32'h00000000, 4'd8},
    '{1'b0, 1'b0, 3'd0, 12'h380, 32'h00000000, 4'd8},
    '{1'b1, 1'b0, 3'd0, 12'h110, 32'hFFFFFFFF, 4'd8},
    '{1'b0, 1'b0, 3'd0, 12'h110, 32'h00000000, 4'd8},
    '{1'b1, 1'b0, 3'd2, 12'h404, 32'hDEADBEEF, 4'd9},  // R9
    '{1'b0, 1'b0, 3'd2, 12'h404, 32'hDEADBEEF, 4'd9},
    '{1'b0, 1'b0, 3'd7, 12'h404, 32'h00000000, 4'd12},
    '{1'b1, 1'b0, 3'd0, 12'h47C, 32'h11223344, 4'd9},
    '{1'b0, 1'b0, 3'd5, 12'h47C, 32'h11223344, 4'd9},
    '{1'b1, 1'b0, 3'd0, 12'hC08, 32'hFFFFFFFF, 4'd10}, // R10
    '{1'b0, 1'b0, 3'd0, 12'hC08, 32'hAAAAAAAA, 4'd10},
    '{1'b1, 1'b0, 3'd0, 12'hC0C, 32'h00000008, 4'd10},
    '{1'b0, 1'b0, 3'd0, 12'hC0C, 32'h00000008, 4'd10},
    '{1'b1, 1'b0, 3'd0, 12'hC0C, 32'h00000004, 4'd10},
    '{1'b0, 1'b0, 3'd0, 12'hC0C, 32'h00000000, 4'd10},
    '{1'b1, 1'b0, 3'd1, 12'hC04, 32'h00000000, 4'd12},
    '{1'b0, 1'b0, 3'd1, 12'hC04, 32'h00000000, 4'd12},
    '{1'b0, 1'b0, 3'd2, 12'hC04, 32'hAAAAAAAA, 4'd12},
    '{1'b1, 1'b0, 3'd1, 12'hC00, 32'h00000000, 4'd11}, // R11
    '{1'b0, 1'b0, 3'd1, 12'hC04, 32'hAAAAAAAA, 4'd11},
    '{1'b0, 1'b0, 3'd1, 12'hC00, 32'hAAAAAAAA, 4'd11}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cpu = '0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        chg;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dist_regs dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cpu_i       (cpu),
    .addr_i      (addr),
    .we_i        (we),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .state_chg_o (chg)
  );

  task automatic check(int req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr_word(logic [2:0] c, logic [11:0] a, logic [31:0] d, logic stb, int req);
    @(negedge clk);
    cpu = c; addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    check(req, {31'b0, chg}, {31'b0, stb});
  endtask

  task automatic rd_word(logic [2:0] c, logic [11:0] a, logic [31:0] exp, int req);
    @(negedge clk);
    cpu = c; addr = a; we = 1'b0;
    #1;
    check(req, rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_word(3'd0, 12'h000, 32'h00000000, 1);
    rd_word(3'd0, 12'h100, 32'h0000FFFF, 1);
    rd_word(3'd7, 12'h180, 32'h0000FFFF, 1);
    rd_word(3'd0, 12'h200, 32'h00000000, 1);
    rd_word(3'd0, 12'h400, 32'h00000000, 1);
    rd_word(3'd0, 12'hC00, 32'hAAAAAAAA, 1);
    rd_word(3'd5, 12'hC04, 32'hAAAAAAAA, 1);
    rd_word(3'd0, 12'hC08, 32'h00000000, 1);
    check(1, {31'b0, chg}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr)
        wr_word(VECS[i].cpu, VECS[i].addr, VECS[i].dat, VECS[i].stb, int'(VECS[i].req));
      else
        rd_word(VECS[i].cpu, VECS[i].addr, VECS[i].dat, int'(VECS[i].req));
    end

    // R13: strobe lasts exactly one cycle after a write
    wr_word(3'd0, 12'h280, 32'h00000001, 1'b1, 13);
    @(negedge clk);
    check(13, {31'b0, chg}, 32'h0);
    // R13: write to configuration does not strobe
    wr_word(3'd0, 12'hC10, 32'h00000002, 1'b0, 13);

    // R1: reset mid-run restores initial state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_word(3'd1, 12'h104, 32'h00000000, 1);
    rd_word(3'd3, 12'h100, 32'h0000FFFF, 1);
    rd_word(3'd2, 12'h404, 32'h00000000, 1);
    rd_word(3'd1, 12'hC04, 32'hAAAAAAAA, 1);
    rd_word(3'd0, 12'hC08, 32'h00000000, 1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule